// File: doc/BRIEF.md
# SPI Channel Sequencer

This block manages one master channel of a multichannel SPI controller. It holds the channel's configuration word, its enable bit and three status flags. It decides when the next serial word may go out, and it raises the channel's DMA requests. A host reaches five channel registers through a small strobe-based register port. Writing the transmit register and reading the receive register are the events that drive the channel forward.

A transfer attempt starts a word only if the channel is enabled and the status flags allow it. The gating depends on the transfer mode: full duplex, receive-only or transmit-only. A turbo bit lets a word go out while an earlier received word is still unread. When the controller runs in single-channel mode, a channel shifts on the bus only if its force bit is set. Without the force bit, the flags still step as if the word had been sent, but the bus stays quiet. The serial side is a mode-0 master. It sends MSB first at a fixed clock divider, samples the input line on rising edges, and holds chip-select low for the whole word.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset, STAT reads 0x2 (only TXS), CONF reads 0x060000, CTRL and TX read 0, both DMA requests are low and csN is high. Register indices: 0 CONF, 1 CTRL (bit0 enable), 2 STAT (bit0 RXS, bit1 TXS, bit2 EOT), 3 TX, 4 RX.
- R2: modeBad is high while CONF bits 13:12 equal 3. lenBad is high while the CONF bits 11:7 field is below 3.
- R3: With the enable bit clear, a TX write only loads the data and clears TXS, and no word is shifted. A later write that takes the enable bit from 0 to 1 makes a transfer attempt.
- R4: The word length is the CONF bits 11:7 field plus one. A word puts exactly that many rising sclk edges on the bus, all while csN is low. mosi carries the TX data MSB first, and RX receives the bits sampled on miso.
- R5: A completed word clears TX to 0 and sets EOT and TXS. It also sets RXS unless the mode is transmit-only.
- R6: A transfer attempt is refused while RXS is set, turbo (CONF bit19) is clear and the mode is not transmit-only. Reading RX clears RXS and makes an attempt, so the held word then goes out.
- R7: With turbo set, a set RXS does not refuse an attempt. The new word overwrites RX.
- R8: In transmit-only mode (CONF 13:12 = 2), RXS is never set and back-to-back TX writes each send a word.
- R9: In receive-only mode (CONF 13:12 = 1), TXS does not refuse an attempt. Enabling the channel starts a word, and each RX read starts the next one.
- R10: While singleMode is high and CONF bit20 is clear, an accepted attempt shifts nothing and leaves RX unchanged. It still clears TX and updates the status flags. With CONF bit20 set, the word is shifted.
- R11: txDmaReq is high exactly when the channel is enabled, CONF bit14 is set, TXS is set and the mode is not receive-only.
- R12: rxDmaReq is high exactly when the channel is enabled, CONF bit15 is set, RXS is set and the mode is not transmit-only.
- R13: CONF keeps only its low 23 bits, so writing all ones reads back 0x7FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on RX) |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| singleMode | input | 1 | Controller-level single-channel mode |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Chip-select, active low |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| modeBad | output | 1 | Illegal transfer mode configured |
| lenBad | output | 1 | Illegal word length configured |

## Verification
The bench writes TX a second time while an unread word sits in RX. A design that ignored RXS would send that second word at once, and one that forgot the attempt on the RX read would never send it. It also runs turbo, transmit-only and receive-only sequences. Getting the mode gating wrong there would show up as a stalled channel or as a stray RXS. The word-length table includes 4-bit and 32-bit words and non-byte lengths, which catches an off-by-one in the length field or in the receive mask. It also runs single-channel mode with and without the force bit, and a design that shifted anyway would toggle sclk.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W = 6;
  localparam int unsigned CONF_W = 23;
  localparam logic [CONF_W-1:0] CONF_RST = 23'h060000;

  localparam int unsigned WL_LO = 7;
  localparam int unsigned MODE_LO = 12;
  localparam int unsigned DMA_TX_BIT = 14;
  localparam int unsigned DMA_RX_BIT = 15;
  localparam int unsigned TURBO_BIT = 19;
  localparam int unsigned FORCE_BIT = 20;

  typedef enum logic [1:0] {
    MODE_DUPLEX = 2'd0,
    MODE_RXONLY = 2'd1,
    MODE_TXONLY = 2'd2,
    MODE_BAD    = 2'd3
  } xferMode_e;

  typedef enum logic [2:0] {
    REG_CONF = 3'd0,
    REG_CTRL = 3'd1,
    REG_STAT = 3'd2,
    REG_TX   = 3'd3,
    REG_RX   = 3'd4
  } regSel_e;

  typedef struct packed {
    logic loadTx;
    logic startShift;
    logic clearTx;
  } dpStrobe_t;
endpackage

// File: rtl/spi_chan_dp.sv
module spi_chan_dp
  import spi_chan_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic              miso,
  output logic [DATA_W-1:0] txHold,
  output logic [DATA_W-1:0] rxHold,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic              csN
);
  localparam int unsigned CNT_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [DATA_W-1:0] shReg, shNext, lenMask;
  logic [CNT_W-1:0]  divCnt;
  logic [LEN_W-1:0]  bitCnt, lenQ;
  logic              sampBit, sclkQ, csNQ, halfTick;

  assign halfTick = (divCnt == CNT_W'(SCLK_HALF - 1));
  assign shNext   = {shReg[DATA_W-2:0], sampBit};
  assign lenMask  = {DATA_W{1'b1}} >> (LEN_W'(DATA_W) - lenQ);
  assign done     = !csNQ && halfTick && sclkQ && (bitCnt == lenQ - LEN_W'(1));
  assign busy     = !csNQ;
  assign sclk     = sclkQ;
  assign csN      = csNQ;
  assign mosi     = !csNQ && shReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      lenQ    <= LEN_W'(DATA_W);
      sampBit <= 1'b0;
      sclkQ   <= 1'b0;
      csNQ    <= 1'b1;
      rxHold  <= '0;
    end else if (strb.startShift) begin
      shReg  <= txHold << (LEN_W'(DATA_W) - wordLen);
      lenQ   <= wordLen;
      bitCnt <= '0;
      divCnt <= '0;
      sclkQ  <= 1'b0;
      csNQ   <= 1'b0;
    end else if (!csNQ) begin
      if (halfTick) begin
        divCnt <= '0;
        if (!sclkQ) begin
          sclkQ   <= 1'b1;
          sampBit <= miso;
        end else begin
          sclkQ  <= 1'b0;
          shReg  <= shNext;
          bitCnt <= bitCnt + LEN_W'(1);
          if (done) begin
            csNQ   <= 1'b1;
            rxHold <= shNext & lenMask;
          end
        end
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txHold <= '0;
    else if (strb.loadTx) txHold <= wrData;
    else if (done || strb.clearTx) txHold <= '0;
  end

  a_r4_sclk_in_word: assert property (@(posedge clk) disable iff (!rstN)
    sclkQ |-> !csNQ);

  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.startShift |-> csNQ);
endmodule

// File: rtl/spi_chan_ctrl.sv
module spi_chan_ctrl
  import spi_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              singleMode,
  input  logic              dpBusy,
  input  logic              dpDone,
  input  logic [DATA_W-1:0] txHold,
  input  logic [DATA_W-1:0] rxHold,
  output dpStrobe_t         strb,
  output logic [DATA_W-1:0] regRdData,
  output logic [LEN_W-1:0]  wordLen,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              modeBad,
  output logic              lenBad
);
  logic [CONF_W-1:0] conf;
  logic chanEn, rxs, txs, eot, tryReq;
  logic wrConf, wrCtrl, wrTx, rdRx, enRise;
  logic holdRx, holdTx, goNow, doShift, finish;
  xferMode_e mode;

  assign mode    = xferMode_e'(conf[MODE_LO+1:MODE_LO]);
  assign wordLen = {1'b0, conf[WL_LO+4:WL_LO]} + LEN_W'(1);
  assign modeBad = (mode == MODE_BAD);
  assign lenBad  = (conf[WL_LO+4:WL_LO] < 5'd3);

  assign wrConf = regWrEn && (regAddr == REG_CONF);
  assign wrCtrl = regWrEn && (regAddr == REG_CTRL);
  assign wrTx   = regWrEn && (regAddr == REG_TX);
  assign rdRx   = regRdEn && (regAddr == REG_RX);
  assign enRise = wrCtrl && regWrData[0] && !chanEn;

  assign holdRx  = rxs && (mode != MODE_TXONLY) && !conf[TURBO_BIT];
  assign holdTx  = txs && (mode != MODE_RXONLY);
  assign goNow   = tryReq && !dpBusy && chanEn && !holdRx && !holdTx;
  assign doShift = !singleMode || conf[FORCE_BIT];

  assign strb.loadTx     = wrTx;
  assign strb.startShift = goNow && doShift;
  assign strb.clearTx    = goNow && !doShift;
  assign finish          = dpDone || strb.clearTx;

  assign txDmaReq = chanEn && conf[DMA_TX_BIT] && txs && (mode != MODE_RXONLY);
  assign rxDmaReq = chanEn && conf[DMA_RX_BIT] && rxs && (mode != MODE_TXONLY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      conf   <= CONF_RST;
      chanEn <= 1'b0;
      tryReq <= 1'b0;
      rxs    <= 1'b0;
      txs    <= 1'b1;
      eot    <= 1'b0;
    end else begin
      if (wrConf) conf <= regWrData[CONF_W-1:0];
      if (wrCtrl) chanEn <= regWrData[0];
      if (wrTx || rdRx || enRise) tryReq <= 1'b1;
      else if (!dpBusy) tryReq <= 1'b0;
      if (wrTx) txs <= 1'b0;
      if (rdRx) rxs <= 1'b0;
      if (finish) begin
        eot <= 1'b1;
        txs <= 1'b1;
        if (mode != MODE_TXONLY) rxs <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_CONF: regRdData = {{(DATA_W-CONF_W){1'b0}}, conf};
      REG_CTRL: regRdData = {{(DATA_W-1){1'b0}}, chanEn};
      REG_STAT: regRdData = {{(DATA_W-3){1'b0}}, eot, txs, rxs};
      REG_TX:   regRdData = txHold;
      REG_RX:   regRdData = rxHold;
      default:  regRdData = '0;
    endcase
  end

  a_r5_done_flags: assert property (@(posedge clk) disable iff (!rstN)
    dpDone |=> (txs && eot));

  a_r8_txonly_rxs_clear: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TXONLY && !rxs) |=> !rxs);

  a_r6_rx_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (rxs && mode != MODE_TXONLY && !conf[TURBO_BIT]) |-> !(strb.startShift || strb.clearTx));
endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
  import spi_chan_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        singleMode,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        csN,
  output logic        txDmaReq,
  output logic        rxDmaReq,
  output logic        modeBad,
  output logic        lenBad
);
  dpStrobe_t         strb;
  logic [DATA_W-1:0] txHold, rxHold;
  logic [LEN_W-1:0]  wordLen;
  logic              dpBusy, dpDone;

  spi_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .singleMode(singleMode),
    .dpBusy(dpBusy), .dpDone(dpDone), .txHold(txHold), .rxHold(rxHold),
    .strb(strb), .regRdData(regRdData), .wordLen(wordLen),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .modeBad(modeBad), .lenBad(lenBad)
  );

  spi_chan_dp #(.SCLK_HALF(SCLK_HALF)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData), .wordLen(wordLen),
    .miso(miso), .txHold(txHold), .rxHold(rxHold), .busy(dpBusy), .done(dpDone),
    .sclk(sclk), .mosi(mosi), .csN(csN)
  );
endmodule

// File: tb/spi_chan_seq_bench.sv
module spi_chan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_WAIT = 160;

  typedef struct packed {
    logic [4:0]  wl;
    logic        inv;
    logic [31:0] tx;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{5'd7,  1'b0, 32'h0000_00A5, 32'h0000_00A5},
    '{5'd31, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{5'd3,  1'b1, 32'h1234_567C, 32'h0000_0003},
    '{5'd15, 1'b0, 32'hFFFF_0F0F, 32'h0000_0F0F},
    '{5'd11, 1'b1, 32'h0000_0ABC, 32'h0000_0543}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, singleMode = 1'b0, misoInv = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic sclk, mosi, miso, csN, txDmaReq, rxDmaReq, modeBad, lenBad;

  int nCheck = 0;
  int nBad = 0;
  int capCnt = 0;
  int sclkIdle = 0;
  logic [31:0] capWord = 32'd0;

  assign miso = mosi ^ misoInv;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge sclk) begin
    capWord <= {capWord[30:0], mosi};
    capCnt  <= capCnt + 1;
    if (csN) sclkIdle <= sclkIdle + 1;
  end

  spi_chan_seq u_spi_chan_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .singleMode(singleMode), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .modeBad(modeBad), .lenBad(lenBad)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nCheck++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitWord();
    repeat (WORD_WAIT) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", nCheck + 1, nBad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(3'd2, d); check("R1 stat", d, 32'h2);
    rdReg(3'd0, d); check("R1 conf", d, 32'h060000);
    rdReg(3'd1, d); check("R1 ctrl", d, 32'h0);
    rdReg(3'd3, d); check("R1 tx", d, 32'h0);
    check("R1 csN/dma", {29'd0, csN, txDmaReq, rxDmaReq}, 32'h4);

    // R13 conf width, R2 illegal flags
    wrReg(3'd0, 32'hFFFF_FFFF);
    rdReg(3'd0, d); check("R13 conf mask", d, 32'h7F_FFFF);
    check("R2 mode 3 flagged", {30'd0, modeBad, lenBad}, 32'h2);
    wrReg(3'd0, 32'h0000_0100);
    check("R2 length field 2 flagged", {30'd0, modeBad, lenBad}, 32'h1);

    // R3 disabled channel
    wrReg(3'd0, 32'h0000_0380);
    c0 = capCnt;
    wrReg(3'd3, 32'h0000_005A);
    waitWord();
    check("R3 no shift while disabled", capCnt - c0, 0);
    rdReg(3'd2, d); check("R3 only TXS cleared", d, 32'h0);
    wrReg(3'd1, 32'h1);
    waitWord();
    check("R3 enable rise sends word", capCnt - c0, 8);
    rdReg(3'd2, d); check("R3 stat after word", d, 32'h7);
    rdReg(3'd4, d); check("R3 rx", d, 32'h5A);

    // R4 / R5 table of word lengths
    foreach (VECS[i]) begin
      logic [31:0] msk;
      msk = 32'hFFFF_FFFF >> (31 - VECS[i].wl);
      misoInv = VECS[i].inv;
      wrReg(3'd0, {20'd0, VECS[i].wl, 7'd0});
      c0 = capCnt;
      wrReg(3'd3, VECS[i].tx);
      waitWord();
      check("R4 sclk count", capCnt - c0, VECS[i].wl + 1);
      check("R4 mosi msb first", capWord & msk, VECS[i].tx & msk);
      rdReg(3'd2, d); check("R5 stat", d, 32'h7);
      rdReg(3'd3, d); check("R5 tx cleared", d, 32'h0);
      rdReg(3'd4, d); check("R4 rx value", d, VECS[i].exp);
    end
    misoInv = 1'b0;
    check("R4 no sclk outside word", sclkIdle, 0);

    // R6 hold-off by unread RX
    wrReg(3'd0, 32'h0000_0380);
    wrReg(3'd3, 32'h11);
    waitWord();
    c0 = capCnt;
    wrReg(3'd3, 32'h22);
    waitWord();
    check("R6 held while RXS", capCnt - c0, 0);
    rdReg(3'd2, d); check("R6 stat held", d, 32'h5);
    rdReg(3'd4, d); check("R6 first rx", d, 32'h11);
    waitWord();
    check("R6 released by RX read", capCnt - c0, 8);
    rdReg(3'd4, d); check("R6 second rx", d, 32'h22);

    // R7 turbo
    wrReg(3'd0, 32'h0008_0380);
    wrReg(3'd3, 32'h33);
    waitWord();
    c0 = capCnt;
    wrReg(3'd3, 32'h44);
    waitWord();
    check("R7 turbo not held", capCnt - c0, 8);
    rdReg(3'd4, d); check("R7 rx overwritten", d, 32'h44);

    // R8 transmit-only
    wrReg(3'd0, 32'h0000_2380);
    wrReg(3'd3, 32'h55);
    waitWord();
    rdReg(3'd2, d); check("R8 no RXS", d, 32'h6);
    c0 = capCnt;
    wrReg(3'd3, 32'h66);
    waitWord();
    check("R8 back to back", capCnt - c0, 8);
    check("R8 mosi", capWord & 32'hFF, 32'h66);

    // R9 receive-only
    wrReg(3'd0, 32'h0000_1380);
    misoInv = 1'b1;
    c0 = capCnt;
    wrReg(3'd1, 32'h0);
    wrReg(3'd1, 32'h1);
    waitWord();
    check("R9 enable starts word", capCnt - c0, 8);
    rdReg(3'd2, d); check("R9 stat", d, 32'h7);
    rdReg(3'd4, d); check("R9 rx", d, 32'hFF);
    waitWord();
    check("R9 RX read starts next", capCnt - c0, 16);
    wrReg(3'd0, 32'h0000_0380);
    misoInv = 1'b0;
    rdReg(3'd4, d);

    // R11 / R12 DMA requests
    wrReg(3'd0, 32'h0000_C380);
    check("R11 tx req idle", {30'd0, txDmaReq, rxDmaReq}, 32'h2);
    wrReg(3'd3, 32'h77);
    check("R11 tx req drops on write", {31'd0, txDmaReq}, 32'h0);
    waitWord();
    check("R12 both req after word", {30'd0, txDmaReq, rxDmaReq}, 32'h3);
    wrReg(3'd0, 32'h0000_D380);
    check("R11 rx-only masks tx req", {30'd0, txDmaReq, rxDmaReq}, 32'h1);
    wrReg(3'd0, 32'h0000_E380);
    check("R12 tx-only masks rx req", {30'd0, txDmaReq, rxDmaReq}, 32'h2);
    wrReg(3'd0, 32'h0000_C380);
    rdReg(3'd4, d); check("R12 rx data", d, 32'h77);
    check("R12 rx req drops", {31'd0, rxDmaReq}, 32'h0);
    wrReg(3'd1, 32'h0);
    check("R11 disabled no req", {31'd0, txDmaReq}, 32'h0);

    // R10 single-channel mode and force
    wrReg(3'd1, 32'h1);
    wrReg(3'd0, 32'h0000_0380);
    singleMode = 1'b1;
    c0 = capCnt;
    wrReg(3'd3, 32'h88);
    repeat (20) @(negedge clk);
    check("R10 no shift", capCnt - c0, 0);
    check("R10 csN stays high", {31'd0, csN}, 32'h1);
    rdReg(3'd2, d); check("R10 flags updated", d, 32'h7);
    rdReg(3'd3, d); check("R10 tx cleared", d, 32'h0);
    rdReg(3'd4, d); check("R10 rx unchanged", d, 32'h77);
    wrReg(3'd0, 32'h0010_0380);
    wrReg(3'd3, 32'h99);
    waitWord();
    check("R10 force shifts", capCnt - c0, 8);
    rdReg(3'd4, d); check("R10 force rx", d, 32'h99);
    singleMode = 1'b0;

    $display("test done: total=%0d bad=%0d", nCheck, nBad);
    $finish;
  end
endmodule